// File: doc/BRIEF.md
# Video Clamp Pulse Generator

This block drives the black-level clamp strobe of a three-channel video digitiser. Its timing is counted in pixel clocks from the reference edge of horizontal sync. A polarity input picks which sync edge counts: rising for a positive sync pulse, falling for a negative one. In the internal mode, a counter waits a programmed number of pixels after each reference edge and then holds the clamp for a programmed number of pixels. In the external mode, the clamp follows a dedicated pin instead, and a polarity bit turns the pin level into an active-high strobe.

The block also outputs one ground/midscale selector per colour channel, for example for luma/chroma inputs whose chroma channels rest at midscale. Placement, duration and the channel selectors are captured at each reference edge, so a register write during a line takes effect on the next line. The source select and both polarity inputs act at once.

The sequencer has three states. IDLE waits for a reference edge. WAIT counts down the placement. ACTIVE counts down the duration while the clamp is asserted. The transitions are:
- edge-restart: any state goes to WAIT on a reference edge.
- place-expire: WAIT goes to ACTIVE when the placement count runs out.
- zero-width: WAIT goes to IDLE when the count runs out and the captured duration is 0.
- width-expire: ACTIVE goes to IDLE when the duration count runs out.

Top module: `vclamp_gen`

## Requirements
- R1: After reset, `clamp_out` and `mid_sel_out` are 0. With the internal source, no clamp appears until the first reference edge is captured.
- R2: The sync input passes through two register stages. With `cfg_hs_high`=1 a rising transition is the reference edge; with 0 a falling transition is. The opposite transition has no effect. A transition on the sync input that is first sampled at clock edge k is captured at clock edge k+1.
- R3: If a reference edge is captured at clock edge E with placement P, the internal clamp is high after clock edge E+P and not before. A placement of 0 behaves as 1.
- R4: The internal clamp stays high for exactly D clock cycles, where D is the captured duration. A duration of 0 produces no clamp on that line.
- R5: A reference edge captured while the clamp is in WAIT or ACTIVE ends any clamp at that clock edge and restarts the placement count.
- R6: Placement, duration and the channel selectors are sampled only at a captured reference edge. Changes between edges affect only the next line.
- R7: With `cfg_ext_sel`=1, `clamp_out` equals the `clamp_pin` level sampled at the previous clock edge, XOR `cfg_ext_low` sampled at that same edge. So `cfg_ext_low`=1 makes a low pin mean clamp, and 0 makes a high pin mean clamp. Placement and duration have no effect in this mode.
- R8: `mid_sel_out[2]` is red, `[1]` is green and `[0]` is blue. A 1 selects midscale and a 0 selects ground.
- R9: `cfg_ext_sel` takes effect in the same cycle, even in the middle of a line. The internal sequencer keeps counting while the external source is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_in | input | 1 | Raw horizontal sync |
| clamp_pin | input | 1 | External clamp pin |
| cfg_place | input | 8 | Pixels from reference edge to clamp start |
| cfg_width | input | 8 | Clamp length in pixels |
| cfg_ext_sel | input | 1 | 1 selects the external pin as clamp source |
| cfg_ext_low | input | 1 | 1 means the external pin is active low |
| cfg_hs_high | input | 1 | 1 means sync is active high (rising edge is the reference) |
| cfg_mid_sel | input | 3 | Per-channel midscale select {red, green, blue} |
| clamp_out | output | 1 | Active-high clamp strobe |
| mid_sel_out | output | 3 | Captured per-channel midscale select |

## Verification
Several properties are checked on every cycle:
- An internal clamp run never exceeds the captured duration.
- The clamp only starts out of WAIT.
- A captured edge drops the internal clamp in the next cycle.
- IDLE stays IDLE without an edge.
- The channel selectors hold between edges.
- The external mode reproduces the normalised pin one cycle later.

Only the bench scenarios can show the exact start cycle after placement, that placement 0 behaves as 1, and the behaviour at the 255 boundary. The same holds for the choice of edge under each sync polarity, for mid-line writes landing on the next line, and for restarts of a clamp that is still running, which are compared against a cycle model built from the requirements.

// File: rtl/vclamp_pkg.sv
package vclamp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WAIT   = 2'd1,
        ST_ACTIVE = 2'd2
    } clamp_state_e;
endpackage

// File: rtl/vclamp_edge.sv
module vclamp_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic hs_in,
    input  logic hs_high,
    output logic ref_edge
);
    logic hs_d1;
    logic hs_d2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_d1 <= 1'b0;
            hs_d2 <= 1'b0;
        end else begin
            hs_d1 <= hs_in;
            hs_d2 <= hs_d1;
        end
    end

    // Leading edge of the sync pulse under the selected polarity
    assign ref_edge = hs_high ? (hs_d1 & ~hs_d2) : (~hs_d1 & hs_d2);
endmodule

// File: rtl/vclamp_ext.sv
module vclamp_ext (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic active_low,
    output logic ext_active
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ext_active <= 1'b0;
        else        ext_active <= pin ^ active_low;
    end
endmodule

// File: rtl/vclamp_fsm.sv
module vclamp_fsm
    import vclamp_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_edge,
    input  logic [CNT_W-1:0] place,
    input  logic [CNT_W-1:0] width,
    output logic             active,
    output clamp_state_e     state_o,
    output logic [CNT_W-1:0] width_q
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    clamp_state_e     state, state_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic [CNT_W-1:0] width_n;
    logic [CNT_W-1:0] place_eff;

    assign place_eff = (place == '0) ? ONE : place;

    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        width_n = width_q;
        if (ref_edge) begin
            // edge-restart
            state_n = ST_WAIT;
            cnt_n   = place_eff;
            width_n = width;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    state_n = ST_IDLE;
                end
                ST_WAIT: begin
                    if (cnt == ONE) begin
                        if (width_q == '0) begin
                            state_n = ST_IDLE;     // zero-width
                        end else begin
                            state_n = ST_ACTIVE;   // place-expire
                            cnt_n   = width_q;
                        end
                    end else begin
                        cnt_n = cnt - ONE;
                    end
                end
                ST_ACTIVE: begin
                    if (cnt == ONE) state_n = ST_IDLE;  // width-expire
                    else            cnt_n   = cnt - ONE;
                end
                default: state_n = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            width_q <= '0;
        end else begin
            state   <= state_n;
            cnt     <= cnt_n;
            width_q <= width_n;
        end
    end

    always_comb begin
        active  = (state == ST_ACTIVE);
        state_o = state;
    end
endmodule

// File: rtl/vclamp_gen.sv
module vclamp_gen
    import vclamp_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int NCH   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hsync_in,
    input  logic             clamp_pin,
    input  logic [CNT_W-1:0] cfg_place,
    input  logic [CNT_W-1:0] cfg_width,
    input  logic             cfg_ext_sel,
    input  logic             cfg_ext_low,
    input  logic             cfg_hs_high,
    input  logic [NCH-1:0]   cfg_mid_sel,
    output logic             clamp_out,
    output logic [NCH-1:0]   mid_sel_out
);
    logic             edge_pulse;
    logic             fsm_active;
    logic             ext_active;
    clamp_state_e     fsm_state;
    logic [CNT_W-1:0] width_q;

    vclamp_edge edge_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .hs_in    (hsync_in),
        .hs_high  (cfg_hs_high),
        .ref_edge (edge_pulse)
    );

    vclamp_fsm #(.CNT_W(CNT_W)) fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_edge (edge_pulse),
        .place    (cfg_place),
        .width    (cfg_width),
        .active   (fsm_active),
        .state_o  (fsm_state),
        .width_q  (width_q)
    );

    vclamp_ext ext_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin        (clamp_pin),
        .active_low (cfg_ext_low),
        .ext_active (ext_active)
    );

    // Per-channel selectors, captured at each reference edge
    for (genvar ch = 0; ch < NCH; ch++) begin : g_mid
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          mid_sel_out[ch] <= 1'b0;
            else if (edge_pulse) mid_sel_out[ch] <= cfg_mid_sel[ch];
        end
    end

    assign clamp_out = cfg_ext_sel ? ext_active : fsm_active;
endmodule

// File: rtl/vclamp_chk.sv
module vclamp_chk
    import vclamp_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int NCH   = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             edge_pulse,
    input logic             fsm_active,
    input clamp_state_e     fsm_state,
    input logic [CNT_W-1:0] width_q,
    input logic             ext_sel,
    input logic             ext_low,
    input logic             clamp_pin,
    input logic             clamp_out,
    input logic [NCH-1:0]   mid_out
);
    logic           past_ok;
    logic [CNT_W:0] run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            past_ok <= 1'b0;
            run     <= '0;
        end else begin
            past_ok <= 1'b1;
            run     <= fsm_active ? run + 1'b1 : '0;
        end
    end

    a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_IDLE && !edge_pulse) |=> (fsm_state == ST_IDLE));

    a_r3_enter_from_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $rose(fsm_active)) |-> ($past(fsm_state) == ST_WAIT));

    a_r4_width_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_active |-> (run < {1'b0, width_q}));

    a_r5_edge_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_pulse && !ext_sel) |=> (ext_sel || !clamp_out));

    a_r6_mid_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !edge_pulse) |=> $stable(mid_out));

    a_r7_ext_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && ext_sel) |-> (clamp_out == ($past(clamp_pin) ^ $past(ext_low))));
endmodule

bind vclamp_gen vclamp_chk #(.CNT_W(CNT_W), .NCH(NCH)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .edge_pulse (edge_pulse),
    .fsm_active (fsm_active),
    .fsm_state  (fsm_state),
    .width_q    (width_q),
    .ext_sel    (cfg_ext_sel),
    .ext_low    (cfg_ext_low),
    .clamp_pin  (clamp_pin),
    .clamp_out  (clamp_out),
    .mid_out    (mid_sel_out)
);

// File: tb/vclamp_gen_tb.sv
`timescale 1ns/1ps
module vclamp_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hs = 1'b0;
    logic       pin = 1'b0;
    logic [7:0] place = 8'd5;
    logic [7:0] width = 8'd4;
    logic       ext_sel = 1'b0;
    logic       ext_low = 1'b1;
    logic       hs_high = 1'b1;
    logic [2:0] mid = 3'b000;
    logic       clamp_out;
    logic [2:0] mid_sel_out;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 0;
    bit  rand_pin = 0;
    string tag = "R1";

    // reference model state
    int         k = 0;
    int         e = 0;
    int         lp = 1;
    int         ld = 0;
    bit         have = 0;
    logic [2:0] lmid = 3'b000;
    logic       m1 = 1'b0;
    logic       m2 = 1'b0;

    always #2 clk = ~clk;

    vclamp_gen dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .hsync_in    (hs),
        .clamp_pin   (pin),
        .cfg_place   (place),
        .cfg_width   (width),
        .cfg_ext_sel (ext_sel),
        .cfg_ext_low (ext_low),
        .cfg_hs_high (hs_high),
        .cfg_mid_sel (mid),
        .clamp_out   (clamp_out),
        .mid_sel_out (mid_sel_out)
    );

    function automatic bit exp_clamp(input int now);
        if (ext_sel) return pin ^ ext_low;
        if (!have) return 1'b0;
        return ((now - e) >= lp) && ((now - e) < lp + ld);
    endfunction

    task automatic tick();
        bit   cap;
        logic ec;
        @(posedge clk);
        cap = hs_high ? (!m2 && m1) : (m2 && !m1);
        m2 = m1;
        m1 = hs;
        k++;
        if (cap) begin
            e = k;
            lp = (place == 8'd0) ? 1 : int'(place);
            ld = int'(width);
            lmid = mid;
            have = 1;
        end
        ec = exp_clamp(k);
        #1;
        n_chk++;
        if (clamp_out !== ec) begin
            n_fail++;
            $display("FAIL %s clamp_out actual=%0b expected=%0b at cycle %0d", tag, clamp_out, ec, k);
        end
        n_chk++;
        if (mid_sel_out !== lmid) begin
            n_fail++;
            $display("FAIL R6/R8 mid_sel_out actual=%b expected=%b at cycle %0d", mid_sel_out, lmid, k);
        end
        if (rand_pin) pin = 1'($urandom);
    endtask

    task automatic line(input int act, input int idle);
        for (int i = 0; i < act; i++) begin hs = hs_high; tick(); end
        for (int i = 0; i < idle; i++) begin hs = ~hs_high; tick(); end
    endtask

    initial begin
        void'($urandom(32'h5EED));
        repeat (3) @(posedge clk);
        #1;
        n_chk++;
        if (clamp_out !== 1'b0 || mid_sel_out !== 3'b000) begin
            n_fail++;
            $display("FAIL R1 reset outputs actual=%0b/%b expected=0/000", clamp_out, mid_sel_out);
        end
        rst_n = 1'b1;
        tag = "R1";
        for (int i = 0; i < 10; i++) tick();

        tag = "R3";  place = 8'd5; width = 8'd4; mid = 3'b101;
        line(3, 30); line(3, 30);
        tag = "R3";  place = 8'd0; width = 8'd3;
        line(2, 20);
        tag = "R4";  place = 8'd4; width = 8'd0;
        line(2, 20);
        tag = "R3";  place = 8'd255; width = 8'd2;
        line(4, 290);
        tag = "R4";  place = 8'd1; width = 8'd255;
        line(2, 280);
        tag = "R5";  place = 8'd10; width = 8'd50;
        line(2, 20); line(2, 20); line(2, 70);
        tag = "R6";  place = 8'd6; width = 8'd5; mid = 3'b010;
        hs = 1'b1; tick(); hs = 1'b0; tick();
        place = 8'd20; width = 8'd1; mid = 3'b111;
        for (int i = 0; i < 30; i++) tick();
        line(2, 30);
        tag = "R8";  mid = 3'b100; line(2, 10);
        mid = 3'b001; line(2, 10);
        tag = "R2";  hs_high = 1'b0; place = 8'd3; width = 8'd6;
        line(5, 25); line(5, 25);
        hs_high = 1'b1; line(4, 25);
        tag = "R7";  ext_sel = 1'b1; rand_pin = 1; ext_low = 1'b1;
        line(3, 40);
        ext_low = 1'b0; place = 8'd2; width = 8'd30;
        line(3, 40);
        tag = "R9";  ext_sel = 1'b0; place = 8'd8; width = 8'd20;
        hs = 1'b1; tick(); hs = 1'b0;
        for (int i = 0; i < 12; i++) tick();
        ext_sel = 1'b1; for (int i = 0; i < 5; i++) tick();
        ext_sel = 1'b0; for (int i = 0; i < 20; i++) tick();

        tag = "R3";
        for (int n = 0; n < 160; n++) begin
            place   = 8'($urandom_range(0, 60));
            width   = 8'($urandom_range(0, 60));
            mid     = 3'($urandom);
            ext_sel = ($urandom_range(0, 4) == 0);
            ext_low = 1'($urandom);
            if ($urandom_range(0, 9) == 0) hs_high = ~hs_high;
            line($urandom_range(1, 8), $urandom_range(5, 120));
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule